// File: doc/BRIEF.md
# Command Stream Method Expander

This block sits between a command-word fetcher and a set of register-programmed engines. It takes a list of 32-bit command words and turns every header and the argument words that follow it into single register-write events. Each event names a method (a 13-bit register number), a 3-bit subchannel and a 32-bit value. The length of a list, counted in words, is loaded before the list starts. The block accepts exactly that many words and then reports completion.

A header selects one of several address-generation modes. The method can step up by one for each argument, stay fixed, or stay on the base for the first argument and move to base+1 for every later one. An inline mode needs no argument word at all, because the value travels inside the header. Mode codes the block does not support raise a sticky error, and the block then discards the rest of the list. Words enter and writes leave on valid/ready handshakes. A held-back output stalls the input, so no word is lost.

Top module: `cmd_expander`

## Requirements
- R1: A header is split into these fields: bits [12:0] method, bits [15:13] subchannel, bits [28:16] argument count or immediate, bits [31:29] mode. In modes 0 and 1, argument k (counting from 0) is written to method+k modulo 2^13, with the header's subchannel.
- R2: In modes 2 and 3, every argument is written to the header's method unchanged.
- R3: Mode 4 takes no argument word. It emits one write to the header's method, and the value is header bits [28:16] zero-extended to 32 bits. The next word is parsed as a header.
- R4: In mode 5, the first argument goes to the method and every later argument goes to method+1. A mode 5 header with count 0 is treated as an unsupported header (see R6) and produces no write.
- R5: A header in modes 0 to 3 with count 0 produces no write, and the next word is parsed as a header.
- R6: A header with mode 6 or 7 sets `mode_err`. The remaining words of that list are accepted but produce no write. `mode_err` stays set until reset and does not stop later lists.
- R7: Exactly `list_len` words, headers and arguments together, are accepted per list. An argument run that the length cuts short simply ends. After the last word, `busy` and `in_ready` fall, and `list_done` is high for one cycle.
- R8: While `out_valid` is high and `out_ready` is low, the output fields hold steady and `in_ready` is low. Writes leave in order, with none lost or duplicated.
- R9: After reset, `busy`, `out_valid`, `in_ready`, `list_done` and `mode_err` are all low.
- R10: `list_load` has an effect only while the block is idle; a load during a list is ignored. Loading a length of zero gives one `list_done` pulse and no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_load | input | 1 | Load a new list length (idle only) |
| list_len | input | LEN_W | List length in 32-bit words |
| in_valid | input | 1 | Command word valid |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted this cycle |
| out_valid | output | 1 | Register write pending |
| out_ready | input | 1 | Consumer accepts the write |
| out_method | output | 13 | Method number of the write |
| out_sub | output | 3 | Subchannel of the write |
| out_value | output | 32 | Data of the write |
| busy | output | 1 | A list is in progress |
| list_done | output | 1 | One-cycle pulse after the last word |
| mode_err | output | 1 | Sticky unsupported-mode flag |

## Verification
Each mode is driven with headers whose methods, subchannels and arguments differ, so that a wrong field slice or a wrong step rule changes the observed method sequence. One incrementing run starts at the top method so that it must wrap to zero. Headers with count zero, and a list too short for its argument run, separate a correct count tracker from one that parses arguments as headers or the reverse. A run under a slow, periodic `out_ready` tells correct stalling from dropped or repeated writes. Lists with unsupported modes, followed by inline-looking words, show that discarding is complete and that the error flag persists.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int WORD_W = 32;
  localparam int METH_W = 13;
  localparam int SUB_W  = 3;
  localparam int CNT_W  = 13;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_INC_A  = 3'd0,
    MODE_INC_B  = 3'd1,
    MODE_SAME_A = 3'd2,
    MODE_SAME_B = 3'd3,
    MODE_IMM    = 3'd4,
    MODE_ONCE   = 3'd5,
    MODE_RSV6   = 3'd6,
    MODE_RSV7   = 3'd7
  } cmd_mode_e;

  typedef struct packed {
    cmd_mode_e         mode;
    logic [CNT_W-1:0]  cnt;
    logic [SUB_W-1:0]  sub;
    logic [METH_W-1:0] method;
  } cmd_hdr_t;

  // Method of argument number idx under a given mode
  function automatic logic [METH_W-1:0] method_for(cmd_mode_e m,
                                                   logic [METH_W-1:0] base,
                                                   logic [CNT_W-1:0] idx);
    logic [METH_W-1:0] step;
    step = '0;
    case (m)
      MODE_INC_A, MODE_INC_B: step = METH_W'(idx);
      MODE_ONCE:              step = (idx != '0) ? METH_W'(1) : '0;
      default:                step = '0;
    endcase
    return base + step;
  endfunction

  function automatic logic hdr_is_bad(cmd_hdr_t h);
    return (h.mode == MODE_RSV6) || (h.mode == MODE_RSV7) ||
           ((h.mode == MODE_ONCE) && (h.cnt == '0));
  endfunction
endpackage

// File: rtl/cse_hdr_decode.sv
module cse_hdr_decode
  import cse_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_hdr_t          hdr,
  output logic              is_bad,
  output logic              is_imm,
  output logic              has_args,
  output logic [WORD_W-1:0] imm_value
);
  always_comb begin
    hdr       = cmd_hdr_t'(word);
    is_bad    = hdr_is_bad(hdr);
    is_imm    = (hdr.mode == MODE_IMM);
    has_args  = !is_bad && !is_imm && (hdr.cnt != '0);
    imm_value = WORD_W'(hdr.cnt);
  end
endmodule

// File: rtl/cse_len_track.sv
module cse_len_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [LEN_W-1:0] load_len,
  input  logic             take,
  output logic             busy,
  output logic             last_word,
  output logic             done
);
  logic [LEN_W-1:0] remain_q;
  logic             done_q;
  logic             load_ok;

  assign busy      = (remain_q != '0);
  assign last_word = (remain_q == LEN_W'(1));
  assign load_ok   = load_req && !busy;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_ok) begin
        remain_q <= load_len;
        done_q   <= (load_len == '0);
      end else if (take) begin
        remain_q <= remain_q - LEN_W'(1);
        if (last_word) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cse_arg_seq.sv
module cse_arg_seq
  import cse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last_word,
  input  logic [WORD_W-1:0] word,
  input  cmd_hdr_t          hdr,
  input  logic              is_bad,
  input  logic              is_imm,
  input  logic              has_args,
  input  logic [WORD_W-1:0] imm_value,
  output logic              emit,
  output logic [METH_W-1:0] emit_method,
  output logic [SUB_W-1:0]  emit_sub,
  output logic [WORD_W-1:0] emit_value,
  output logic              discarding,
  output logic              mode_err
);
  logic              in_args_q;
  logic              discard_q;
  logic              err_q;
  cmd_mode_e         mode_q;
  logic [METH_W-1:0] base_q;
  logic [SUB_W-1:0]  sub_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  idx_q;

  assign discarding = discard_q;
  assign mode_err   = err_q;

  always_comb begin
    emit        = 1'b0;
    emit_method = hdr.method;
    emit_sub    = hdr.sub;
    emit_value  = imm_value;
    if (discard_q) begin
      emit = 1'b0;
    end else if (!in_args_q) begin
      emit = is_imm;
    end else begin
      emit        = 1'b1;
      emit_method = method_for(mode_q, base_q, idx_q);
      emit_sub    = sub_q;
      emit_value  = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_args_q <= 1'b0;
      discard_q <= 1'b0;
      err_q     <= 1'b0;
      mode_q    <= MODE_INC_A;
      base_q    <= '0;
      sub_q     <= '0;
      left_q    <= '0;
      idx_q     <= '0;
    end else if (take) begin
      if (!discard_q && !in_args_q && is_bad) err_q <= 1'b1;
      if (last_word) begin
        in_args_q <= 1'b0;
        discard_q <= 1'b0;
      end else if (discard_q) begin
        discard_q <= 1'b1;
      end else if (!in_args_q) begin
        if (is_bad) begin
          discard_q <= 1'b1;
        end else if (has_args) begin
          in_args_q <= 1'b1;
          mode_q    <= hdr.mode;
          base_q    <= hdr.method;
          sub_q     <= hdr.sub;
          left_q    <= hdr.cnt;
          idx_q     <= '0;
        end
      end else begin
        idx_q  <= idx_q + CNT_W'(1);
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) in_args_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cse_out_stage.sv
module cse_out_stage
  import cse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [METH_W-1:0] ld_method,
  input  logic [SUB_W-1:0]  ld_sub,
  input  logic [WORD_W-1:0] ld_value,
  input  logic              ready,
  output logic              valid,
  output logic [METH_W-1:0] method,
  output logic [SUB_W-1:0]  sub,
  output logic [WORD_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      method <= '0;
      sub    <= '0;
      value  <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      method <= ld_method;
      sub    <= ld_sub;
      value  <= ld_value;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_expander.sv
module cmd_expander
  import cse_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                list_load,
  input  logic [LEN_W-1:0]    list_len,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [METH_W-1:0]   out_method,
  output logic [SUB_W-1:0]    out_sub,
  output logic [WORD_W-1:0]   out_value,
  output logic                busy,
  output logic                list_done,
  output logic                mode_err
);
  cmd_hdr_t          hdr;
  logic              is_bad, is_imm, has_args;
  logic [WORD_W-1:0] imm_value;
  logic              last_word;
  logic              word_take;
  logic              emit, emit_fire, discarding;
  logic [METH_W-1:0] emit_method;
  logic [SUB_W-1:0]  emit_sub;
  logic [WORD_W-1:0] emit_value;

  assign in_ready  = busy && (!out_valid || out_ready);
  assign word_take = in_valid && in_ready;
  assign emit_fire = word_take && emit;

  cse_hdr_decode u_dec (
    .word(in_word), .hdr(hdr), .is_bad(is_bad), .is_imm(is_imm),
    .has_args(has_args), .imm_value(imm_value)
  );

  cse_len_track #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load_req(list_load), .load_len(list_len),
    .take(word_take), .busy(busy), .last_word(last_word), .done(list_done)
  );

  cse_arg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(word_take), .last_word(last_word),
    .word(in_word), .hdr(hdr), .is_bad(is_bad), .is_imm(is_imm),
    .has_args(has_args), .imm_value(imm_value), .emit(emit),
    .emit_method(emit_method), .emit_sub(emit_sub), .emit_value(emit_value),
    .discarding(discarding), .mode_err(mode_err)
  );

  cse_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(emit_fire), .ld_method(emit_method),
    .ld_sub(emit_sub), .ld_value(emit_value), .ready(out_ready),
    .valid(out_valid), .method(out_method), .sub(out_sub), .value(out_value)
  );
endmodule

// File: rtl/cse_checker.sv
module cse_checker
  import cse_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [METH_W-1:0] out_method,
  input logic [SUB_W-1:0]  out_sub,
  input logic [WORD_W-1:0] out_value,
  input logic              busy,
  input logic              list_done,
  input logic              mode_err,
  input logic              emit_fire
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_method) &&
                                   $stable(out_sub) && $stable(out_value)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> !busy);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  assert_emit_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    emit_fire |=> out_valid);
endmodule

bind cmd_expander cse_checker chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_method(out_method), .out_sub(out_sub),
  .out_value(out_value), .busy(busy), .list_done(list_done),
  .mode_err(mode_err), .emit_fire(emit_fire)
);

// File: tb/cmd_expander_tb_top.sv
module cmd_expander_tb_top;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             list_load = 1'b0;
  logic [LEN_W-1:0] list_len = '0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_word = '0;
  logic             in_ready;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [12:0]      out_method;
  logic [2:0]       out_sub;
  logic [31:0]      out_value;
  logic             busy, list_done, mode_err;

  always #2 clk = ~clk;

  cmd_expander #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .list_load(list_load), .list_len(list_len),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_method(out_method),
    .out_sub(out_sub), .out_value(out_value), .busy(busy),
    .list_done(list_done), .mode_err(mode_err)
  );

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int hold_err = 0;
  int stall_err = 0;
  int cyc = 0;
  bit bp = 1'b0;

  logic [12:0] got_m [0:31];
  logic [2:0]  got_s [0:31];
  logic [31:0] got_v [0:31];
  int          got_n = 0;
  logic [12:0] exp_m [0:31];
  logic [2:0]  exp_s [0:31];
  logic [31:0] exp_v [0:31];
  int          exp_n = 0;
  logic [31:0] lw [0:15];

  function automatic logic [31:0] mk_hdr(int mode, int cnt, int sub, int meth);
    mk_hdr = {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_add(input int m, input int s, input int v);
    exp_m[exp_n] = m[12:0];
    exp_s[exp_n] = s[2:0];
    exp_v[exp_n] = v;
    exp_n++;
  endtask

  // ready pattern, driven at falling edges
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: samples 1 ns before each rising edge
  logic        pv_stall = 1'b0;
  logic [12:0] pv_m;
  logic [2:0]  pv_s;
  logic [31:0] pv_v;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (pv_stall && !(out_valid && out_method == pv_m && out_sub == pv_s && out_value == pv_v))
          hold_err++;
        if (out_valid && !out_ready && in_ready) stall_err++;
        pv_stall = out_valid && !out_ready;
        pv_m = out_method; pv_s = out_sub; pv_v = out_value;
        if (out_valid && out_ready && got_n < 32) begin
          got_m[got_n] = out_method;
          got_s[got_n] = out_sub;
          got_v[got_n] = out_value;
          got_n++;
        end
        if (list_done) done_cnt++;
      end
    end
  end

  task automatic push(input logic [31:0] w);
    bit acc;
    in_valid = 1'b1;
    in_word  = w;
    do begin
      #1 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic start_list(input int n);
    got_n = 0;
    list_load = 1'b1;
    list_len  = n[LEN_W-1:0];
    @(negedge clk);
    list_load = 1'b0;
  endtask

  task automatic finish_list(input string req, input int d0);
    repeat (10) @(negedge clk);
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_m[i] == exp_m[i], req, got_m[i], exp_m[i]);
      chk(got_s[i] == exp_s[i], req, got_s[i], exp_s[i]);
      chk(got_v[i] == exp_v[i], req, got_v[i], exp_v[i]);
    end
    chk(done_cnt == d0 + 1, "R7 done pulse", done_cnt, d0 + 1);
    chk(!busy && !in_ready, "R7 idle after list", {busy, in_ready}, 0);
  endtask

  task automatic run_list(input int n, input string req);
    int d0;
    d0 = done_cnt;
    start_list(n);
    for (int i = 0; i < n; i++) push(lw[i]);
    finish_list(req, d0);
  endtask

  task automatic t_reset();
    chk({busy, out_valid, in_ready, list_done, mode_err} == 5'b0, "R9 reset state",
        {busy, out_valid, in_ready, list_done, mode_err}, 0);
  endtask

  task automatic t_increasing();
    lw[0] = mk_hdr(1, 3, 2, 'h100);
    lw[1] = 32'hA0; lw[2] = 32'hA1; lw[3] = 32'hA2;
    lw[4] = mk_hdr(0, 2, 7, 'h1FFF);
    lw[5] = 32'hDEAD0001; lw[6] = 32'hDEAD0002;
    exp_n = 0;
    exp_add('h100, 2, 'hA0); exp_add('h101, 2, 'hA1); exp_add('h102, 2, 'hA2);
    exp_add('h1FFF, 7, 'hDEAD0001); exp_add('h0000, 7, 'hDEAD0002);
    run_list(7, "R1 increasing");
  endtask

  task automatic t_same();
    lw[0] = mk_hdr(3, 3, 1, 'h44);
    lw[1] = 32'h11; lw[2] = 32'h22; lw[3] = 32'h33;
    lw[4] = mk_hdr(2, 1, 0, 'h45); lw[5] = 32'h55;
    exp_n = 0;
    exp_add('h44, 1, 'h11); exp_add('h44, 1, 'h22); exp_add('h44, 1, 'h33);
    exp_add('h45, 0, 'h55);
    run_list(6, "R2 same method");
  endtask

  task automatic t_inline();
    lw[0] = mk_hdr(4, 'h1ABC, 5, 'h12);
    lw[1] = mk_hdr(4, 'h1FFF, 6, 'h13);
    exp_n = 0;
    exp_add('h12, 5, 'h1ABC); exp_add('h13, 6, 'h1FFF);
    run_list(2, "R3 inline");
  endtask

  task automatic t_once();
    lw[0] = mk_hdr(5, 4, 3, 'h200);
    lw[1] = 32'h1; lw[2] = 32'h2; lw[3] = 32'h3; lw[4] = 32'h4;
    lw[5] = mk_hdr(5, 1, 4, 'h300); lw[6] = 32'h77;
    exp_n = 0;
    exp_add('h200, 3, 1); exp_add('h201, 3, 2); exp_add('h201, 3, 3); exp_add('h201, 3, 4);
    exp_add('h300, 4, 'h77);
    run_list(7, "R4 increase once");
  endtask

  task automatic t_zero_count();
    lw[0] = mk_hdr(0, 0, 1, 'h10);
    lw[1] = mk_hdr(3, 0, 2, 'h20);
    lw[2] = mk_hdr(4, 'h5, 3, 'h30);
    exp_n = 0;
    exp_add('h30, 3, 5);
    run_list(3, "R5 zero count");
  endtask

  task automatic t_truncate();
    lw[0] = mk_hdr(1, 5, 0, 'h30); lw[1] = 32'hBEEF;
    exp_n = 0;
    exp_add('h30, 0, 'hBEEF);
    run_list(2, "R7 truncated run");
    lw[0] = mk_hdr(4, 9, 1, 'h31);
    exp_n = 0;
    exp_add('h31, 1, 9);
    run_list(1, "R7 header after truncation");
  endtask

  task automatic t_load_busy();
    int d0;
    d0 = done_cnt;
    exp_n = 0;
    exp_add('h50, 2, 'hC1); exp_add('h51, 2, 'hC2);
    start_list(3);
    push(mk_hdr(0, 2, 2, 'h50));
    list_load = 1'b1; list_len = 9;
    @(negedge clk);
    list_load = 1'b0;
    push(32'hC1); push(32'hC2);
    finish_list("R10 load while busy ignored", d0);
    d0 = done_cnt;
    start_list(0);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1 && !busy, "R10 zero length", done_cnt, d0 + 1);
  endtask

  task automatic t_backpressure();
    lw[0] = mk_hdr(1, 6, 5, 'h600);
    for (int i = 1; i <= 6; i++) lw[i] = 32'h9000 + i;
    exp_n = 0;
    for (int i = 0; i < 6; i++) exp_add('h600 + i, 5, 'h9001 + i);
    bp = 1'b1;
    run_list(7, "R8 backpressure");
    bp = 1'b0;
    chk(hold_err == 0, "R8 output held", hold_err, 0);
    chk(stall_err == 0, "R8 input stalled", stall_err, 0);
  endtask

  task automatic t_errors();
    chk(!mode_err, "R6 no error before", mode_err, 0);
    lw[0] = mk_hdr(5, 0, 1, 'h40);
    lw[1] = mk_hdr(4, 3, 1, 'h41);
    exp_n = 0;
    run_list(2, "R4 count zero rejected");
    chk(mode_err, "R4 count zero flags error", mode_err, 1);
    lw[0] = mk_hdr(7, 2, 0, 'h42);
    lw[1] = mk_hdr(4, 1, 0, 'h43);
    lw[2] = mk_hdr(4, 2, 0, 'h44);
    lw[3] = 32'h0;
    run_list(4, "R6 mode 7 discards");
    lw[0] = mk_hdr(6, 1, 0, 'h45);
    lw[1] = mk_hdr(4, 1, 0, 'h46);
    run_list(2, "R6 mode 6 discards");
    lw[0] = mk_hdr(4, 'h1234, 2, 'h47);
    exp_add('h47, 2, 'h1234);
    run_list(1, "R6 later list still runs");
    chk(mode_err, "R6 error sticky", mode_err, 1);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    #1 t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_increasing();
    t_same();
    t_inline();
    t_once();
    t_zero_count();
    t_truncate();
    t_load_busy();
    t_backpressure();
    t_errors();
    report();
  end
endmodule